// File: doc/BRIEF.md
# Asynchronous Static RAM Byte Access Controller

This block sits between a synchronous user port and an external asynchronous static RAM of 64K bytes. Each transfer moves one byte. The user raises a request with a 16-bit address and a write flag. The request is taken in the cycle where the ready output is high. For a read, the controller later returns the byte together with a one-cycle valid strobe.

On the memory side the controller drives these signals from flops:
- an active-low select and an active-high select;
- an active-low output enable and an active-low write enable;
- the address, the write data, and a driver-enable for the shared data bus.

It also samples the returned byte. Every pulse length and gap is derived at elaboration from nanosecond limits and the clock period, using ceiling division. With the default 10 ns clock, both reads and writes last 9 cycles.

Writes are controlled by the write-enable strobe, and the output enable stays high for the whole write. After every read the controller keeps the bus quiet for a turnaround of at least 3 cycles before it accepts new work. This lets the memory's output drivers release the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and after it is released, req_ready is 1, mem_ce1_n is 1, mem_ce2 is 0, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and rd_valid is 0.
- R2: The memory is selected (mem_ce1_n=0 and mem_ce2=1) exactly during a transfer. Selection starts in the cycle after acceptance. At all other times it is deselected (mem_ce1_n=1, mem_ce2=0).
- R3: A read keeps the select and mem_oe_n=0 for 9 cycles (default) with mem_addr equal to the accepted address. mem_we_n stays 1 throughout.
- R4: Read data is captured from mem_din on the last read cycle. It appears on rd_data with rd_valid=1 for exactly one cycle, namely the cycle after the read's last one.
- R5: A write holds mem_oe_n=1 and mem_dq_oe=1 for all 9 cycles (default), with mem_dout equal to the accepted byte and mem_addr equal to the accepted address.
- R6: In a write, mem_we_n is 0 in the first 7 cycles (default) and 1 in the remaining 2. It is low only while the memory is selected.
- R7: After a read, req_ready stays 0 for 3 more cycles (default) in which the memory is deselected and the bus is not driven.
- R8: A request is taken only when req_valid and req_ready are both 1. req_ready is 0 throughout a transfer, and request inputs that change during that time have no effect.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| mem_ce1_n | output | 1 | Active-low memory select |
| mem_ce2 | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low memory output enable |
| mem_we_n | output | 1 | Active-low memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_dout | output | 8 | Byte driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_din | input | 8 | Byte read back from the data bus |

## Verification
The hardest situation to bring about is a write that immediately follows a read, because this is where the turnaround gap protects the shared bus. The stimulus keeps req_valid high continuously, so every read-then-write pair in the operation list reaches the controller at the earliest cycle it is allowed. While the controller is busy, the stimulus puts scrambled addresses and data on the request inputs to show they are ignored. A behavioural memory model in the bench stores bytes on write-enable rising edges. Reading the bytes back proves that the write path and the address and data hold worked.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_TURN} sram_state_e;

  function automatic int cdiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 9,
  parameter int WR_CYC   = 9,
  parameter int TURN_CYC = 3,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output sram_state_e      state,
  output logic [CNT_W-1:0] cnt,
  output logic             start,
  output logic             rd_last,
  output logic             wr_last
);
  logic turn_last;

  always_comb begin
    start     = req_valid && req_ready;
    rd_last   = (state == ST_READ)  && (cnt == CNT_W'(RD_CYC - 1));
    wr_last   = (state == ST_WRITE) && (cnt == CNT_W'(WR_CYC - 1));
    turn_last = (state == ST_TURN)  && (cnt == CNT_W'(TURN_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      req_ready <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state     <= req_write ? ST_WRITE : ST_READ;
          cnt       <= '0;
          req_ready <= 1'b0;
        end
        ST_READ: if (rd_last) begin
          state <= ST_TURN;
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
        ST_WRITE: if (wr_last) begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: if (turn_last) begin
          state     <= ST_IDLE;
          req_ready <= 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int AS_CYC = 0,
  parameter int WP_CYC = 7,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             req_write,
  input  sram_state_e      state,
  input  logic [CNT_W-1:0] cnt,
  input  logic             rd_last,
  input  logic             wr_last,
  output logic             mem_ce1_n,
  output logic             mem_ce2,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_dq_oe
);
  int  nxt;
  logic we_low_nxt;

  always_comb begin
    nxt        = int'(cnt) + 1;
    we_low_nxt = (nxt >= AS_CYC) && (nxt < AS_CYC + WP_CYC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else if (start) begin
      mem_ce1_n <= 1'b0;
      mem_ce2   <= 1'b1;
      mem_oe_n  <= req_write;
      mem_we_n  <= !(req_write && (AS_CYC == 0));
      mem_dq_oe <= req_write;
    end else if (rd_last || wr_last) begin
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else if (state == ST_WRITE) begin
      mem_we_n  <= !we_low_nxt;
    end
  end
endmodule

// File: rtl/sram_ctrl_data.sv
module sram_ctrl_data #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dout <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_last;
      if (start) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (rd_last) rd_data <= mem_din;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_RC_NS   = 85,
  parameter int T_AA_NS   = 85,
  parameter int T_WC_NS   = 85,
  parameter int T_WP_NS   = 60,
  parameter int T_AW_NS   = 70,
  parameter int T_AS_NS   = 0,
  parameter int T_DW_NS   = 35,
  parameter int T_WR_NS   = 5,
  parameter int T_OHZ_NS  = 30,
  parameter int MIN_TURN  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int RD_CYC   = imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS));
  localparam int AS_CYC   = cdiv(T_AS_NS, CLK_NS);
  localparam int WP_CYC   = imax(cdiv(T_WP_NS, CLK_NS),
                                 imax(cdiv(T_AW_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS)) - AS_CYC);
  localparam int WR_CYC   = imax(cdiv(T_WC_NS, CLK_NS), AS_CYC + WP_CYC + cdiv(T_WR_NS, CLK_NS));
  localparam int TURN_CYC = imax(MIN_TURN, cdiv(T_OHZ_NS, CLK_NS));
  localparam int CNT_W    = $clog2(imax(imax(RD_CYC, WR_CYC), TURN_CYC) + 1);

  sram_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             start, rd_last, wr_last;

  sram_ctrl_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .state(state), .cnt(cnt), .start(start),
    .rd_last(rd_last), .wr_last(wr_last)
  );

  sram_ctrl_pins #(.AS_CYC(AS_CYC), .WP_CYC(WP_CYC), .CNT_W(CNT_W)) u_pins (
    .clk(clk), .rst(rst), .start(start), .req_write(req_write), .state(state),
    .cnt(cnt), .rd_last(rd_last), .wr_last(wr_last), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
  );

  sram_ctrl_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .start(start), .rd_last(rd_last), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_din(mem_din), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int WP_CYC   = 7,
  parameter int TURN_CYC = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  logic [7:0] we_run;
  logic [7:0] free_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_run   <= '0;
      free_run <= 8'(TURN_CYC);
    end else begin
      we_run   <= mem_we_n ? 8'd0 : ((we_run == 8'hFF) ? we_run : we_run + 8'd1);
      free_run <= !mem_oe_n ? 8'd0 : ((free_run == 8'hFF) ? free_run : free_run + 8'd1);
    end
  end

  p_sel_pair_r2: assert property (@(posedge clk) disable iff (rst)
    mem_ce1_n == !mem_ce2);
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
  p_rv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_we_sel_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_oe_n));
  p_we_width_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run >= 8'(WP_CYC)));
  p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (free_run >= 8'(TURN_CYC)));
  p_busy_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_ce1_n |-> !req_ready);
  p_no_fight_r9: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .TURN_CYC(TURN_CYC)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD = 9, WR = 9, WP = 7, TURN = 3, NOPS = 14;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, mem_din = '0;
  logic req_ready, rd_valid, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0] rd_data, mem_dout;
  logic [15:0] mem_addr;

  sram_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // operation list
  bit         op_w [NOPS];
  logic [15:0] op_a [NOPS];
  logic [7:0]  op_d [NOPS];
  int idx = 0;

  // memories: device model and reference record
  logic [7:0] dev [int];
  logic [7:0] refm [int];
  function automatic logic [7:0] dflt(input logic [15:0] a);
    return a[15:8] ^ a[7:0];
  endfunction

  // reference model state
  int ph = -1, kind = 0, trn = 0;
  logic [15:0] ea = '0;
  logic [7:0]  ed = '0, erd = '0;
  bit erdy = 1'b1, erv = 1'b0, started = 1'b0, old_rdy;
  int checks = 0, fails = 0, cycles = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      ph = -1; trn = 0; erdy = 1'b1; erv = 1'b0;
    end else begin
      old_rdy = erdy; erv = 1'b0;
      if (ph >= 0) begin
        ph++;
        if (kind == 0 && ph == RD) begin
          erv = 1'b1; erd = refm.exists(int'(ea)) ? refm[int'(ea)] : dflt(ea);
          ph = -1; trn = TURN;
        end else if (kind == 1 && ph == WR) ph = -1;
      end else if (trn > 0) trn--;
      else if (old_rdy && req_valid) begin
        ph = 0; kind = req_write ? 1 : 0; ea = req_addr; ed = req_wdata;
        if (req_write) refm[int'(req_addr)] = req_wdata;
        if (idx < NOPS) idx++;
      end
      erdy = (ph < 0 && trn == 0);
    end
  end

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  logic prev_we = 1'b1;
  bit act_e;
  always @(negedge clk) begin
    cycles++;
    if (started) begin
      act_e = (ph >= 0);
      if (rst) begin
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "ce1_n", int'(mem_ce1_n), 1);
        chk("R1", "rd_valid", int'(rd_valid), 0);
      end
      chk("R8 R7", "req_ready", int'(req_ready), int'(erdy));
      chk("R2", "ce1_n", int'(mem_ce1_n), int'(!act_e));
      chk("R2", "ce2", int'(mem_ce2), int'(act_e));
      chk("R3 R5", "oe_n", int'(mem_oe_n), int'(!(act_e && kind == 0)));
      chk("R6", "we_n", int'(mem_we_n), int'(!(act_e && kind == 1 && ph < WP)));
      chk("R5 R9", "dq_oe", int'(mem_dq_oe), int'(act_e && kind == 1));
      chk("R4", "rd_valid", int'(rd_valid), int'(erv));
      if (erv) chk("R4", "rd_data", int'(rd_data), int'(erd));
      if (act_e) chk("R3 R5", "mem_addr", int'(mem_addr), int'(ea));
      if (act_e && kind == 1) chk("R5", "mem_dout", int'(mem_dout), int'(ed));
    end
    // device model: store on write-enable rise while selected
    if (!prev_we && mem_we_n && !mem_ce1_n && mem_ce2) dev[int'(mem_addr)] = mem_dout;
    prev_we = mem_we_n;
    mem_din <= (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ?
               (dev.exists(int'(mem_addr)) ? dev[int'(mem_addr)] : dflt(mem_addr)) : 8'h00;
    // driver: scrambled inputs while busy (R8: must be ignored)
    if (!rst && idx < NOPS) begin
      req_valid <= 1'b1;
      if (erdy) begin
        req_write <= op_w[idx]; req_addr <= op_a[idx]; req_wdata <= op_d[idx];
      end else begin
        req_write <= cycles[0]; req_addr <= 16'(cycles * 16'h9E37); req_wdata <= 8'(cycles * 7);
      end
    end else req_valid <= 1'b0;
  end

  initial begin
    op_w = '{1,1,1,0,1,0,0,0,0,1,0,1,1,0};
    op_a = '{16'h0000,16'hFFFF,16'h1234,16'h1234,16'h1234,16'h0000,16'hFFFF,
             16'h1234,16'h4321,16'h8000,16'h8000,16'h0001,16'h0002,16'h0001};
    op_d = '{8'hA5,8'h3C,8'h77,8'h00,8'hE1,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'hFF,8'h5A,8'h00};
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    while ((idx < NOPS || !erdy) && cycles < 5000) @(posedge clk);
    repeat (15) @(posedge clk);
    if (cycles >= 5000) begin
      fails++; checks++;
      $display("FAIL R8 watchdog actual=%0d expected<5000", cycles);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule